// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block is the control core of a serial NOR flash. It receives instructions that have already been decoded from the serial bus: write enable, page program, the three erase sizes, status read, flag-status read, suspend and resume. Each instruction arrives with an address and a byte count. The block keeps the write-enable latch and checks every program or erase request against the page, boot-region and latch rules. It runs the internal cycle on a counter, and presents a status byte and a flag-status byte that the host polls to see when the cycle has finished.

The block also reports which bus protocol the pins should use. Quad I/O is the default. Single-line extended mode is reported while a high-voltage assist is applied and the configuration bit that disables the assist is clear. While the assist is active, cycle times are divided by a parameter, and only polling, suspend and resume are accepted. The block returns to quad I/O in the cycle after the assist flag drops.

Top module: `flash_pe_seq`

## Requirements
- R1: A write-enable instruction (op code 1) accepted while no cycle runs sets the write-enable latch, which is `status_o` bit 1.
- R2: A page program (op 2) starts only if the latch is set, the count is 1 to 256, and address bits [7:0] plus the count do not exceed 256. Any other page program is rejected: the latch clears, `flag_o` bit 4 sets, and no cycle starts. An accepted start clears `flag_o` bits 4 and 3.
- R3: Subsector erase (op 3), sector erase (op 4) and bulk erase (op 5) are rejected in the same way when the latch is clear.
- R4: An accepted request holds `status_o` bit 0 high, and `flag_o` bit 7 low, for exactly T_PP, T_SSE, T_SE or T_BE clock cycles according to its op.
- R5: When a cycle completes, `status_o` bit 0 and the latch both clear and `flag_o` bit 7 sets. The latch stays set for the whole cycle.
- R6: A program or erase request that arrives while a cycle runs has no effect on that cycle. It sets `flag_o` bit 3 and leaves the latch unchanged.
- R7: If `assist_hi` is 1 and `cfg_assist_off` is 0 when a request is accepted, `proto_ext_o` becomes 1 and the cycle lasts max(1, T/ASSIST_DIV) cycles.
- R8: While `proto_ext_o` is 1, only status read (op 8), flag read (op 9), suspend (op 6) and resume (op 7) are acted on. All other ops are ignored.
- R9: `proto_ext_o` returns to 0 in the cycle after `assist_hi` is sampled low.
- R10: With BOOT_MODE 0, subsector erase is allowed only in 64 KiB sectors 0 to 7. BOOT_MODE 1 allows only the top 8 sectors. BOOT_MODE 2 (uniform) refuses every subsector erase.
- R11: Suspend during a cycle freezes its counter and sets `flag_o` bit 6. Resume clears bit 6 and finishes the remaining cycles. `status_o` bit 0 stays high throughout.
- R12: Status read and flag read raise `rd_valid_o` for one cycle, in the cycle after the instruction. `rd_data_o` then holds the status or flag byte as it stood when the instruction arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded instruction present this cycle |
| cmd_op | input | 4 | Instruction code (see requirements) |
| cmd_addr | input | ADDR_W | Byte address of the request |
| cmd_len | input | PAGE_W+1 | Page-program byte count |
| assist_hi | input | 1 | High-voltage assist applied |
| cfg_assist_off | input | 1 | Configuration bit; 1 disables the assist |
| status_o | output | 8 | Bit 0 write in progress, bit 1 write-enable latch |
| flag_o | output | 8 | Bit 7 ready, 6 suspended, 4 rejected, 3 collision |
| proto_ext_o | output | 1 | 1 = single-line extended protocol |
| rd_valid_o | output | 1 | Register read data valid |
| rd_data_o | output | 8 | Register read data |

## Verification
Two functions can meet in one clock edge. A polling or suspend instruction can arrive while the cycle counter is still running. A second program request can land on the same edge where a cycle is already active. The bench issues a status read, a suspend and a colliding page program in the middle of running cycles. It then judges the outcome by the remaining cycle count at the ports, which has to match the arithmetic from the start edge, and by the read byte, which has to show the busy state before the instruction arrived. The assisted case is exercised the same way: a read inside the shortened cycle must still succeed in extended mode.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_WREN = 4'd1,
    OP_PP   = 4'd2,
    OP_SSE  = 4'd3,
    OP_SE   = 4'd4,
    OP_BE   = 4'd5,
    OP_SUSP = 4'd6,
    OP_RES  = 4'd7,
    OP_RDSR = 4'd8,
    OP_RDFS = 4'd9
  } op_e;

  localparam int ST_WIP   = 0;
  localparam int ST_WEL   = 1;
  localparam int FL_READY = 7;
  localparam int FL_SUSP  = 6;
  localparam int FL_REJ   = 4;
  localparam int FL_COLL  = 3;

  localparam int BOOT_BOTTOM  = 0;
  localparam int BOOT_TOP     = 1;
  localparam int BOOT_UNIFORM = 2;
endpackage

// File: rtl/fseq_legal.sv
module fseq_legal
  import fseq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_W    = 8,
  parameter int SECT_W    = 16,
  parameter int BOOT_N    = 8,
  parameter int BOOT_MODE = BOOT_BOTTOM
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W:0]   len,
  input  logic              wel,
  output logic              legal
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int NSECT  = 2 ** SIDX_W;
  localparam int SUM_W  = PAGE_W + 2;
  localparam int PAGE   = 2 ** PAGE_W;

  logic [SIDX_W-1:0] sect;
  logic              in_boot;
  logic [SUM_W-1:0]  end_sum;
  logic              pp_fits;

  assign sect = addr[ADDR_W-1:SECT_W];

  generate
    if (BOOT_MODE == BOOT_BOTTOM) begin : g_bottom
      assign in_boot = (sect < SIDX_W'(BOOT_N));
    end else if (BOOT_MODE == BOOT_TOP) begin : g_top
      assign in_boot = (sect >= SIDX_W'(NSECT - BOOT_N));
    end else begin : g_uniform
      assign in_boot = 1'b0;
    end
  endgenerate

  assign end_sum = SUM_W'(addr[PAGE_W-1:0]) + SUM_W'(len);
  assign pp_fits = (len != '0) && (end_sum <= SUM_W'(PAGE));

  always_comb begin
    unique case (op)
      OP_PP:        legal = wel && pp_fits;
      OP_SSE:       legal = wel && in_boot;
      OP_SE, OP_BE: legal = wel;
      default:      legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hold,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && !hold && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && !hold) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fseq_mode.sv
module fseq_mode (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic assisted,
  input  logic assist_hi,
  output logic ext
);
  always_ff @(posedge clk) begin
    if (rst)                    ext <= 1'b0;
    else if (start && assisted) ext <= 1'b1;
    else if (!assist_hi)        ext <= 1'b0;
  end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_W     = 8,
  parameter int SECT_W     = 16,
  parameter int BOOT_N     = 8,
  parameter int BOOT_MODE  = BOOT_BOTTOM,
  parameter int T_PP       = 40,
  parameter int T_SSE      = 60,
  parameter int T_SE       = 100,
  parameter int T_BE       = 200,
  parameter int ASSIST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W:0]   cmd_len,
  input  logic              assist_hi,
  input  logic              cfg_assist_off,
  output logic [7:0]        status_o,
  output logic [7:0]        flag_o,
  output logic              proto_ext_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o
);
  localparam int TMAX  = (T_BE > T_SE) ? ((T_BE > T_SSE) ? ((T_BE > T_PP) ? T_BE : T_PP)
                                                        : ((T_SSE > T_PP) ? T_SSE : T_PP))
                                       : ((T_SE > T_SSE) ? ((T_SE > T_PP) ? T_SE : T_PP)
                                                         : ((T_SSE > T_PP) ? T_SSE : T_PP));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int A_PP  = (T_PP  / ASSIST_DIV > 0) ? T_PP  / ASSIST_DIV : 1;
  localparam int A_SSE = (T_SSE / ASSIST_DIV > 0) ? T_SSE / ASSIST_DIV : 1;
  localparam int A_SE  = (T_SE  / ASSIST_DIV > 0) ? T_SE  / ASSIST_DIV : 1;
  localparam int A_BE  = (T_BE  / ASSIST_DIV > 0) ? T_BE  / ASSIST_DIV : 1;

  op_e              op;
  logic             ext, busy, done, legal, assisted;
  logic             allowed, is_pe, start, reject, collide;
  logic             wel_q, susp_q, rej_q, coll_q;
  logic [CNT_W-1:0] load_val;
  logic [7:0]       stat_w, flag_w;

  assign op       = op_e'(cmd_op);
  assign assisted = assist_hi && !cfg_assist_off;
  assign is_pe    = (op == OP_PP) || (op == OP_SSE) || (op == OP_SE) || (op == OP_BE);
  assign allowed  = cmd_valid && (!ext || op == OP_RDSR || op == OP_RDFS ||
                                  op == OP_SUSP || op == OP_RES);
  assign start    = allowed && is_pe && !busy && legal;
  assign reject   = allowed && is_pe && !busy && !legal;
  assign collide  = allowed && is_pe && busy;

  always_comb begin
    unique case (op)
      OP_PP:   load_val = CNT_W'((assisted ? A_PP  : T_PP)  - 1);
      OP_SSE:  load_val = CNT_W'((assisted ? A_SSE : T_SSE) - 1);
      OP_SE:   load_val = CNT_W'((assisted ? A_SE  : T_SE)  - 1);
      default: load_val = CNT_W'((assisted ? A_BE  : T_BE)  - 1);
    endcase
  end

  fseq_legal #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
    .BOOT_N(BOOT_N), .BOOT_MODE(BOOT_MODE)
  ) u_legal (
    .op(op), .addr(cmd_addr), .len(cmd_len), .wel(wel_q), .legal(legal)
  );

  fseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(start), .load_val(load_val),
    .hold(susp_q), .busy(busy), .done(done)
  );

  fseq_mode u_mode (
    .clk(clk), .rst(rst), .start(start), .assisted(assisted),
    .assist_hi(assist_hi), .ext(ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      susp_q <= 1'b0;
      rej_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      if (done || reject)                          wel_q <= 1'b0;
      else if (allowed && op == OP_WREN && !busy)  wel_q <= 1'b1;

      if (allowed && op == OP_SUSP && busy)        susp_q <= 1'b1;
      else if (allowed && op == OP_RES)            susp_q <= 1'b0;

      if (start)        rej_q <= 1'b0;
      else if (reject)  rej_q <= 1'b1;

      if (start)        coll_q <= 1'b0;
      else if (collide) coll_q <= 1'b1;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_WIP] = busy;
    stat_w[ST_WEL] = wel_q;
    flag_w = '0;
    flag_w[FL_READY] = !busy;
    flag_w[FL_SUSP]  = susp_q;
    flag_w[FL_REJ]   = rej_q;
    flag_w[FL_COLL]  = coll_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= allowed && (op == OP_RDSR || op == OP_RDFS);
      rd_data_o  <= (op == OP_RDSR) ? stat_w : flag_w;
    end
  end

  assign status_o    = stat_w;
  assign flag_o      = flag_w;
  assign proto_ext_o = ext;
endmodule

// File: rtl/fseq_sva.sv
module fseq_sva (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       assist_hi,
  input logic [7:0] status_o,
  input logic [7:0] flag_o,
  input logic       proto_ext_o,
  input logic       rd_valid_o
);
  logic pe_req;
  assign pe_req = cmd_valid && (cmd_op inside {4'd2, 4'd3, 4'd4, 4'd5});

  assert_start_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[0]) |-> $past(pe_req));

  assert_wel_held_R5: assert property (@(posedge clk) disable iff (rst)
    status_o[0] |-> status_o[1]);

  assert_done_clears_wel_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[0]) |-> !status_o[1] && flag_o[7]);

  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (rst)
    pe_req && status_o[0] && !proto_ext_o |=> flag_o[3] && status_o[0]);

  assert_ext_exit_R9: assert property (@(posedge clk) disable iff (rst)
    !assist_hi |=> !proto_ext_o);

  assert_susp_busy_R11: assert property (@(posedge clk) disable iff (rst)
    flag_o[6] |-> status_o[0]);

  assert_read_cause_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(cmd_valid));
endmodule

bind flash_pe_seq fseq_sva u_sva (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .assist_hi(assist_hi), .status_o(status_o), .flag_o(flag_o),
  .proto_ext_o(proto_ext_o), .rd_valid_o(rd_valid_o)
);

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb;
  localparam int TPP = 40, TSSE = 60, TSE = 100, TBE = 200, DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [23:0] cmd_addr = '0;
  logic [8:0]  cmd_len = '0;
  logic        assist_hi = 1'b0;
  logic        cfg_assist_off = 1'b0;
  logic [7:0]  status_o, flag_o, rd_data_o, u_status, u_flag, u_rd;
  logic        proto_ext_o, rd_valid_o, u_ext, u_rv;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_pe_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .assist_hi(assist_hi),
    .cfg_assist_off(cfg_assist_off), .status_o(status_o), .flag_o(flag_o),
    .proto_ext_o(proto_ext_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  flash_pe_seq #(.BOOT_MODE(2)) u_dut_uni (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .assist_hi(assist_hi),
    .cfg_assist_off(cfg_assist_off), .status_o(u_status), .flag_o(u_flag),
    .proto_ext_o(u_ext), .rd_valid_o(u_rv), .rd_data_o(u_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [23:0] a, input logic [8:0] n);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = n;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (status_o[0] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R5 reset status", status_o, 0);
    chk("R5 reset flag", flag_o, 8'h80);
    chk("R9 reset mode", proto_ext_o, 0);
  endtask

  task automatic t_program();
    int n;
    issue(4'd2, 24'h0000F0, 9'd16);
    chk("R2 pp without latch", status_o[0], 0);
    chk("R2 reject flag", flag_o[4], 1);
    issue(4'd1, 0, 0);
    chk("R1 latch set", status_o[1], 1);
    issue(4'd2, 24'h0000F0, 9'd17);
    chk("R2 page cross rejected", status_o[0], 0);
    chk("R2 latch cleared on reject", status_o[1], 0);
    issue(4'd1, 0, 0);
    issue(4'd2, 24'h000010, 9'd0);
    chk("R2 zero count rejected", status_o[0], 0);
    issue(4'd1, 0, 0);
    issue(4'd2, 24'h0000F0, 9'd16);
    chk("R2 reject flag cleared", flag_o[4], 0);
    chk("R4 ready low", flag_o[7], 0);
    measure(n);
    chk("R4 program length", n, TPP);
    chk("R5 latch cleared", status_o[1], 0);
    chk("R5 ready", flag_o[7], 1);
    issue(4'd1, 0, 0);
    issue(4'd2, 24'h000100, 9'd256);
    measure(n);
    chk("R2 full page accepted", n, TPP);
  endtask

  task automatic t_erase();
    int n;
    issue(4'd4, 24'h050000, 0);
    chk("R3 sector erase no latch", status_o[0], 0);
    chk("R3 reject flag", flag_o[4], 1);
    issue(4'd5, 0, 0);
    chk("R3 bulk erase no latch", status_o[0], 0);
    issue(4'd1, 0, 0);
    issue(4'd3, 24'h080000, 0);
    chk("R10 sse outside boot", status_o[0], 0);
    chk("R10 sse outside flag", flag_o[4], 1);
    issue(4'd1, 0, 0);
    issue(4'd3, 24'h071000, 0);
    chk("R10 uniform refuses sse", u_status[0], 0);
    chk("R10 uniform reject flag", u_flag[4], 1);
    measure(n);
    chk("R4 R10 sse length", n, TSSE);
    issue(4'd1, 0, 0);
    issue(4'd5, 0, 0);
    measure(n);
    chk("R4 bulk length", n, TBE);
  endtask

  task automatic t_collide();
    int n;
    issue(4'd1, 0, 0);
    issue(4'd4, 24'h200000, 0);
    issue(4'd2, 24'h000000, 9'd4);
    chk("R6 collision flag", flag_o[3], 1);
    chk("R6 latch kept", status_o[1], 1);
    issue(4'd8, 0, 0);
    chk("R12 read valid", rd_valid_o, 1);
    chk("R12 status byte", rd_data_o, 8'h03);
    issue(4'd9, 0, 0);
    chk("R12 flag byte", rd_data_o, 8'h08);
    @(negedge clk);
    chk("R12 one cycle valid", rd_valid_o, 0);
    measure(n);
    chk("R6 cycle unaffected", n, TSE - 4);
  endtask

  task automatic t_suspend();
    int n;
    issue(4'd1, 0, 0);
    issue(4'd2, 24'h000300, 9'd8);
    repeat (10) @(negedge clk);
    issue(4'd6, 0, 0);
    chk("R11 suspended flag", flag_o[6], 1);
    repeat (30) @(negedge clk);
    chk("R11 wip held", status_o[0], 1);
    issue(4'd7, 0, 0);
    chk("R11 resume clears", flag_o[6], 0);
    measure(n);
    // 11 counting edges before the freeze, none on the resume edge
    chk("R11 remaining cycles", n, TPP - 11);
  endtask

  task automatic t_assist();
    int n;
    assist_hi = 1'b1; cfg_assist_off = 1'b1;
    issue(4'd1, 0, 0);
    issue(4'd4, 24'h300000, 0);
    chk("R7 disabled stays quad", proto_ext_o, 0);
    measure(n);
    chk("R7 disabled full length", n, TSE);
    cfg_assist_off = 1'b0;
    issue(4'd1, 0, 0);
    issue(4'd4, 24'h300000, 0);
    chk("R7 extended mode", proto_ext_o, 1);
    issue(4'd8, 0, 0);
    chk("R8 read in extended", rd_data_o, 8'h03);
    measure(n);
    chk("R7 shortened length", n, TSE / DIV - 1);
    issue(4'd1, 0, 0);
    chk("R8 wren ignored", status_o[1], 0);
    chk("R9 held while assist high", proto_ext_o, 1);
    assist_hi = 1'b0;
    @(negedge clk);
    chk("R9 back to quad", proto_ext_o, 0);
    issue(4'd1, 0, 0);
    chk("R1 wren after exit", status_o[1], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_collide();
    t_suspend();
    t_assist();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule